// File: doc/BRIEF.md
# Rank-Aware Read/Write Burst Scheduler

This block sits between the request queues of a DRAM controller and its command issue stage. Column bursts arrive through two push ports, one per direction. Each burst carries a rank and a bank. A bank timing tracker supplies a per-bank ready vector. Each cycle the block picks one burst from the queue of the direction it is serving. It reports that burst together with the earliest cycle at which it may use the data bus, and it raises `issue` in the cycle the burst goes out. The picked entry leaves its queue at the next clock edge.

A single four-state machine (reading, writing, switching to write, switching to read) decides which queue is served. Bus turnaround gaps are added to the earliest-issue cycle whenever the direction changes or the rank changes. While the direction is steady, a burst to the rank used last is preferred, so that activate and precharge work for it can hide behind the bursts in flight. During a write-to-read switch the chosen read is presented before its bank is ready, so that the tracker can prepare the bank while the bus turns around.

Top module: `burst_sched`

## Requirements
- R1: After reset no burst is selected (`sel_valid`=0), `issue` and `switching` are 0, and the read direction is served.
- R2: Two bursts in the same direction to the same rank issue exactly T_BURST (default 4) cycles apart when both are ready and queued.
- R3: When a burst targets a different rank than the previous burst, T_CS (default 2) extra cycles are added for every combination: read then read, write then write, read then write, and write then read.
- R4: The first write after a read issues T_BURST + T_RTW (default 4+6) cycles after that read when both go to the same rank.
- R5: The first read after a write is presented as `sel_valid`=1 during the switch even when its bank is not ready. It issues once both its bank is ready and T_BURST + T_WTR (+T_CS on a rank change; default 4+8+2) cycles have passed since the write.
- R6: A write is only selected while its bank is ready (`bank_ready` bit index {rank,bank}), including during a read-to-write switch.
- R7: While the direction is steady, a ready entry to the rank of the previous burst is picked ahead of older entries to other ranks.
- R8: With no preferred candidate, the oldest ready entry of the served direction is picked (FIFO order).
- R9: During a direction switch the rank preference is not applied; the oldest eligible entry of the new direction is picked.
- R10: Reading switches to writing when the read queue is empty and a write is queued, or when the write queue holds at least WR_HIGH (default 6) entries. Below WR_HIGH, with reads queued, no switch happens.
- R11: Writing continues until the write queue is empty, even when reads are queued.
- R12: The first burst after reset carries no spacing constraint and issues in the first cycle it is present and ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_push | input | 1 | Append a read burst |
| rd_rank | input | RANK_W | Rank of the pushed read |
| rd_bank | input | BANK_W | Bank of the pushed read |
| rd_full | output | 1 | Read queue is full; a push is dropped |
| wr_push | input | 1 | Append a write burst |
| wr_rank | input | RANK_W | Rank of the pushed write |
| wr_bank | input | BANK_W | Bank of the pushed write |
| wr_full | output | 1 | Write queue is full; a push is dropped |
| bank_ready | input | RANKS*BANKS | Per-bank ready flags from the timing tracker, bit index {rank,bank} |
| sel_valid | output | 1 | A burst is selected |
| sel_write | output | 1 | Selected burst is a write |
| sel_rank | output | RANK_W | Rank of the selected burst |
| sel_bank | output | BANK_W | Bank of the selected burst |
| sel_earliest | output | CYC_W | Earliest cycle the selected burst may issue |
| issue | output | 1 | Selected burst issues this cycle |
| switching | output | 1 | A direction switch is in progress |
| cycle_now | output | CYC_W | Free-running cycle count since reset |

## Verification
The hardest state to reach is a write-to-read switch where the chosen read's bank is still not ready. A read-to-write switch where the write's bank is not ready is just as hard. The directed tasks reach both by holding a single bit of `bank_ready` low and pushing the other-direction burst only after the last burst of the old direction has issued. They then check `sel_valid` in the middle of the turnaround and release the bit at a known cycle. The high-water switch needs reads that are queued but cannot issue. The bench gets there by keeping one rank's banks not ready while writes to the other rank fill the write queue, one entry below the threshold and then at it.

// File: rtl/burst_sched_pkg.sv
package burst_sched_pkg;

   // Served direction and turnaround phase of the scheduler.
   typedef enum logic [1:0] {
      ST_READ     = 2'd0,
      ST_WRITE    = 2'd1,
      ST_TO_WRITE = 2'd2,
      ST_TO_READ  = 2'd3
   } sched_state_e;

   function automatic logic state_is_write(input sched_state_e st);
      return (st == ST_WRITE) || (st == ST_TO_WRITE);
   endfunction

   function automatic logic state_is_switch(input sched_state_e st);
      return (st == ST_TO_WRITE) || (st == ST_TO_READ);
   endfunction

endpackage

// File: rtl/bsched_queue.sv
// Age-ordered burst queue: slot 0 holds the oldest entry. Removal from any
// slot compacts the younger entries down by one position.
module bsched_queue #(
   parameter int DEPTH  = 8,
   parameter int RANK_W = 1,
   parameter int BANK_W = 2,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [RANK_W-1:0] push_rank,
   input  logic [BANK_W-1:0] push_bank,
   input  logic              pop,
   input  logic [IDX_W-1:0]  pop_idx,
   output logic [DEPTH-1:0]  ent_valid,
   output logic [RANK_W-1:0] ent_rank [DEPTH],
   output logic [BANK_W-1:0] ent_bank [DEPTH],
   output logic [CNT_W-1:0]  count,
   output logic              full
);

   logic [RANK_W-1:0] rank_q [DEPTH];
   logic [BANK_W-1:0] bank_q [DEPTH];
   logic [RANK_W-1:0] sh_rank [DEPTH];
   logic [BANK_W-1:0] sh_bank [DEPTH];
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  wr_pos;
   logic              push_ok;
   logic              pop_ok;

   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop && (cnt_q != '0);
   assign wr_pos  = cnt_q - CNT_W'(pop_ok);
   assign count   = cnt_q;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      if (g < DEPTH - 1) begin : g_shift
         logic take_next;
         assign take_next  = pop_ok && (IDX_W'(g) >= pop_idx);
         assign sh_rank[g] = take_next ? rank_q[g+1] : rank_q[g];
         assign sh_bank[g] = take_next ? bank_q[g+1] : bank_q[g];
      end else begin : g_tail
         assign sh_rank[g] = rank_q[g];
         assign sh_bank[g] = bank_q[g];
      end
      assign ent_valid[g] = (CNT_W'(g) < cnt_q);
      assign ent_rank[g]  = rank_q[g];
      assign ent_bank[g]  = bank_q[g];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            rank_q[i] <= '0;
            bank_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (push_ok && (CNT_W'(i) == wr_pos)) begin
               rank_q[i] <= push_rank;
               bank_q[i] <= push_bank;
            end else begin
               rank_q[i] <= sh_rank[i];
               bank_q[i] <= sh_bank[i];
            end
         end
         cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
      end
   end

endmodule

// File: rtl/bsched_pick.sv
// Candidate picker: the oldest eligible entry on the preferred rank wins,
// otherwise the oldest eligible entry of any rank.
module bsched_pick #(
   parameter int DEPTH  = 8,
   parameter int RANK_W = 1,
   parameter int BANK_W = 2,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int NRB   = 1 << (RANK_W + BANK_W)
) (
   input  logic [DEPTH-1:0]  ent_valid,
   input  logic [RANK_W-1:0] ent_rank [DEPTH],
   input  logic [BANK_W-1:0] ent_bank [DEPTH],
   input  logic [NRB-1:0]    bank_ready,
   input  logic              prefer_en,
   input  logic [RANK_W-1:0] pref_rank,
   input  logic              need_ready,
   output logic              found,
   output logic [IDX_W-1:0]  idx,
   output logic [RANK_W-1:0] pick_rank,
   output logic [BANK_W-1:0] pick_bank
);

   logic [DEPTH-1:0] eligible;
   logic [DEPTH-1:0] on_rank;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         eligible[i] = ent_valid[i] &&
                       (!need_ready || bank_ready[{ent_rank[i], ent_bank[i]}]);
         on_rank[i]  = eligible[i] && prefer_en && (ent_rank[i] == pref_rank);
      end
   end

   always_comb begin
      found = |eligible;
      idx   = '0;
      if (|on_rank) begin
         for (int i = DEPTH - 1; i >= 0; i--) begin
            if (on_rank[i]) idx = IDX_W'(i);
         end
      end else begin
         for (int i = DEPTH - 1; i >= 0; i--) begin
            if (eligible[i]) idx = IDX_W'(i);
         end
      end
   end

   assign pick_rank = ent_rank[idx];
   assign pick_bank = ent_bank[idx];

endmodule

// File: rtl/bsched_gap.sv
// Earliest data-bus slot for a candidate, given the previous burst.
module bsched_gap #(
   parameter int T_BURST = 4,
   parameter int T_CS    = 2,
   parameter int T_RTW   = 6,
   parameter int T_WTR   = 8,
   parameter int CYC_W   = 32,
   parameter int RANK_W  = 1
) (
   input  logic              last_valid,
   input  logic [CYC_W-1:0]  last_cyc,
   input  logic [RANK_W-1:0] last_rank,
   input  logic              last_write,
   input  logic [RANK_W-1:0] cand_rank,
   input  logic              cand_write,
   output logic [CYC_W-1:0]  earliest
);

   logic [CYC_W-1:0] rank_pen;
   logic [CYC_W-1:0] dir_pen;

   always_comb begin
      rank_pen = (cand_rank != last_rank) ? CYC_W'(T_CS) : '0;
      if (cand_write == last_write)
         dir_pen = '0;
      else if (cand_write)
         dir_pen = CYC_W'(T_RTW);
      else
         dir_pen = CYC_W'(T_WTR);
      earliest = last_valid ? (last_cyc + CYC_W'(T_BURST) + rank_pen + dir_pen) : '0;
   end

endmodule

// File: rtl/burst_sched.sv
module burst_sched
   import burst_sched_pkg::*;
#(
   parameter int RANKS       = 2,
   parameter int BANKS       = 4,
   parameter int DEPTH       = 8,
   parameter int T_BURST     = 4,
   parameter int T_CS        = 2,
   parameter int T_RTW       = 6,
   parameter int T_WTR       = 8,
   parameter int WR_HIGH     = 6,
   parameter int CYC_W       = 32,
   parameter bit OVERLAP_W2R = 1'b1,
   localparam int RANK_W = $clog2(RANKS),
   localparam int BANK_W = $clog2(BANKS),
   localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int NRB    = RANKS * BANKS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_push,
   input  logic [RANK_W-1:0] rd_rank,
   input  logic [BANK_W-1:0] rd_bank,
   output logic              rd_full,
   input  logic              wr_push,
   input  logic [RANK_W-1:0] wr_rank,
   input  logic [BANK_W-1:0] wr_bank,
   output logic              wr_full,
   input  logic [NRB-1:0]    bank_ready,
   output logic              sel_valid,
   output logic              sel_write,
   output logic [RANK_W-1:0] sel_rank,
   output logic [BANK_W-1:0] sel_bank,
   output logic [CYC_W-1:0]  sel_earliest,
   output logic              issue,
   output logic              switching,
   output logic [CYC_W-1:0]  cycle_now
);

   // Elaboration-time parameter checks
   if (RANKS < 2 || (RANKS & (RANKS - 1)) != 0) begin : g_chk_ranks
      $error("RANKS must be a power of two of at least 2");
   end
   if (BANKS < 2 || (BANKS & (BANKS - 1)) != 0) begin : g_chk_banks
      $error("BANKS must be a power of two of at least 2");
   end
   if (DEPTH < 2) begin : g_chk_depth
      $error("DEPTH must be at least 2");
   end
   if (WR_HIGH < 1 || WR_HIGH > DEPTH) begin : g_chk_high
      $error("WR_HIGH must lie in 1..DEPTH");
   end
   if (T_BURST < 1 || T_CS < 0 || T_RTW < 0 || T_WTR < 0) begin : g_chk_timing
      $error("timing parameters out of range");
   end

   sched_state_e state_q, state_d;
   logic         serve_write;
   logic         in_switch;
   logic         want_switch;
   logic         prefer_en;
   logic         rd_need_ready;
   logic         sel_ready;

   logic [CYC_W-1:0]  cyc_q;
   logic              last_valid_q;
   logic [CYC_W-1:0]  last_cyc_q;
   logic [RANK_W-1:0] last_rank_q;
   logic              last_write_q;

   logic [DEPTH-1:0]  rd_valid, wr_valid;
   logic [RANK_W-1:0] rd_erank [DEPTH];
   logic [BANK_W-1:0] rd_ebank [DEPTH];
   logic [RANK_W-1:0] wr_erank [DEPTH];
   logic [BANK_W-1:0] wr_ebank [DEPTH];
   logic [CNT_W-1:0]  rd_cnt, wr_cnt;

   logic              rd_found, wr_found;
   logic [IDX_W-1:0]  rd_idx, wr_idx;
   logic [RANK_W-1:0] rd_prank, wr_prank;
   logic [BANK_W-1:0] rd_pbank, wr_pbank;

   assign serve_write = state_is_write(state_q);
   assign in_switch   = state_is_switch(state_q);
   assign prefer_en   = last_valid_q && !in_switch;

   // Variant: read bank preparation may overlap the write-to-read turnaround
   if (OVERLAP_W2R) begin : g_w2r_overlap
      assign rd_need_ready = (state_q != ST_TO_READ);
   end else begin : g_w2r_serial
      assign rd_need_ready = 1'b1;
   end

   bsched_queue #(.DEPTH(DEPTH), .RANK_W(RANK_W), .BANK_W(BANK_W)) u_rd_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rd_push),
      .push_rank (rd_rank),
      .push_bank (rd_bank),
      .pop       (issue && !serve_write),
      .pop_idx   (rd_idx),
      .ent_valid (rd_valid),
      .ent_rank  (rd_erank),
      .ent_bank  (rd_ebank),
      .count     (rd_cnt),
      .full      (rd_full)
   );

   bsched_queue #(.DEPTH(DEPTH), .RANK_W(RANK_W), .BANK_W(BANK_W)) u_wr_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_push),
      .push_rank (wr_rank),
      .push_bank (wr_bank),
      .pop       (issue && serve_write),
      .pop_idx   (wr_idx),
      .ent_valid (wr_valid),
      .ent_rank  (wr_erank),
      .ent_bank  (wr_ebank),
      .count     (wr_cnt),
      .full      (wr_full)
   );

   bsched_pick #(.DEPTH(DEPTH), .RANK_W(RANK_W), .BANK_W(BANK_W)) u_rd_pick (
      .ent_valid  (rd_valid),
      .ent_rank   (rd_erank),
      .ent_bank   (rd_ebank),
      .bank_ready (bank_ready),
      .prefer_en  (prefer_en),
      .pref_rank  (last_rank_q),
      .need_ready (rd_need_ready),
      .found      (rd_found),
      .idx        (rd_idx),
      .pick_rank  (rd_prank),
      .pick_bank  (rd_pbank)
   );

   bsched_pick #(.DEPTH(DEPTH), .RANK_W(RANK_W), .BANK_W(BANK_W)) u_wr_pick (
      .ent_valid  (wr_valid),
      .ent_rank   (wr_erank),
      .ent_bank   (wr_ebank),
      .bank_ready (bank_ready),
      .prefer_en  (prefer_en),
      .pref_rank  (last_rank_q),
      .need_ready (1'b1),
      .found      (wr_found),
      .idx        (wr_idx),
      .pick_rank  (wr_prank),
      .pick_bank  (wr_pbank)
   );

   assign sel_valid = serve_write ? wr_found : rd_found;
   assign sel_write = serve_write;
   assign sel_rank  = serve_write ? wr_prank : rd_prank;
   assign sel_bank  = serve_write ? wr_pbank : rd_pbank;
   assign sel_ready = bank_ready[{sel_rank, sel_bank}];

   bsched_gap #(
      .T_BURST (T_BURST),
      .T_CS    (T_CS),
      .T_RTW   (T_RTW),
      .T_WTR   (T_WTR),
      .CYC_W   (CYC_W),
      .RANK_W  (RANK_W)
   ) u_gap (
      .last_valid (last_valid_q),
      .last_cyc   (last_cyc_q),
      .last_rank  (last_rank_q),
      .last_write (last_write_q),
      .cand_rank  (sel_rank),
      .cand_write (sel_write),
      .earliest   (sel_earliest)
   );

   // Direction change decisions; none while a switch is under way
   always_comb begin
      unique case (state_q)
         ST_READ:  want_switch = ((rd_cnt == '0) && (wr_cnt != '0)) ||
                                 (wr_cnt >= CNT_W'(WR_HIGH));
         ST_WRITE: want_switch = (wr_cnt == '0) && (rd_cnt != '0);
         default:  want_switch = 1'b0;
      endcase
   end

   assign issue     = sel_valid && sel_ready && !want_switch &&
                      (cyc_q >= sel_earliest);
   assign switching = in_switch;
   assign cycle_now = cyc_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_READ:     if (want_switch) state_d = ST_TO_WRITE;
         ST_WRITE:    if (want_switch) state_d = ST_TO_READ;
         ST_TO_WRITE: if (issue)       state_d = ST_WRITE;
         ST_TO_READ:  if (issue)       state_d = ST_READ;
         default:                      state_d = ST_READ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_READ;
         cyc_q        <= '0;
         last_valid_q <= 1'b0;
         last_cyc_q   <= '0;
         last_rank_q  <= '0;
         last_write_q <= 1'b0;
      end else begin
         state_q <= state_d;
         cyc_q   <= cyc_q + 1'b1;
         if (issue) begin
            last_valid_q <= 1'b1;
            last_cyc_q   <= cyc_q;
            last_rank_q  <= sel_rank;
            last_write_q <= sel_write;
         end
      end
   end

endmodule

// File: rtl/burst_sched_chk.sv
module burst_sched_chk #(
   parameter int RANKS   = 2,
   parameter int BANKS   = 4,
   parameter int T_BURST = 4,
   parameter int T_CS    = 2,
   parameter int T_RTW   = 6,
   parameter int T_WTR   = 8,
   parameter int CYC_W   = 32,
   localparam int RANK_W = $clog2(RANKS),
   localparam int BANK_W = $clog2(BANKS),
   localparam int NRB    = RANKS * BANKS
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue,
   input logic              sel_valid,
   input logic              sel_write,
   input logic [RANK_W-1:0] sel_rank,
   input logic [BANK_W-1:0] sel_bank,
   input logic [CYC_W-1:0]  sel_earliest,
   input logic [NRB-1:0]    bank_ready,
   input logic [CYC_W-1:0]  cycle_now,
   input logic              switching
);

   // Independent record of the previous issued burst, seen at the ports
   logic              seen_q;
   logic [CYC_W-1:0]  prev_cyc_q;
   logic [RANK_W-1:0] prev_rank_q;
   logic              prev_wr_q;
   logic [CYC_W-1:0]  min_gap;
   logic              sel_bank_rdy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q      <= 1'b0;
         prev_cyc_q  <= '0;
         prev_rank_q <= '0;
         prev_wr_q   <= 1'b0;
      end else if (issue) begin
         seen_q      <= 1'b1;
         prev_cyc_q  <= cycle_now;
         prev_rank_q <= sel_rank;
         prev_wr_q   <= sel_write;
      end
   end

   always_comb begin
      min_gap = CYC_W'(T_BURST);
      if (sel_rank != prev_rank_q) min_gap = min_gap + CYC_W'(T_CS);
      if (sel_write && !prev_wr_q) min_gap = min_gap + CYC_W'(T_RTW);
      if (!sel_write && prev_wr_q) min_gap = min_gap + CYC_W'(T_WTR);
   end

   assign sel_bank_rdy = bank_ready[{sel_rank, sel_bank}];

   // R2 R3 R4 R5: spacing between consecutive issued bursts
   assert_issue_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && seen_q) |-> ((cycle_now - prev_cyc_q) >= min_gap));

   // R2: nothing issues ahead of its reported earliest cycle
   assert_not_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> (cycle_now >= sel_earliest));

   // R5: an issued burst always has a ready bank, even after an overlapped switch
   assert_issue_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> sel_bank_rdy);

   // R6: a selected write always has a ready bank
   assert_write_sel_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && sel_write) |-> sel_bank_rdy);

   // R10: a switch ends only with the first burst of the new direction
   assert_switch_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(switching) |-> $past(issue));

   // R10: a switch never begins in a cycle that issued a burst
   assert_switch_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(switching) |-> !$past(issue));

   // R11: the write side is served across a switch into writing
   assert_switch_dir_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && switching && sel_write) |=> (sel_write && !switching));

endmodule

bind burst_sched burst_sched_chk #(
   .RANKS   (RANKS),
   .BANKS   (BANKS),
   .T_BURST (T_BURST),
   .T_CS    (T_CS),
   .T_RTW   (T_RTW),
   .T_WTR   (T_WTR),
   .CYC_W   (CYC_W)
) i_burst_sched_chk (.*);

// File: tb/test_burst_sched.sv
module test_burst_sched;

   localparam int RANKS = 2;
   localparam int BANKS = 4;
   localparam int CYC_W = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_push = 1'b0, wr_push = 1'b0;
   logic [0:0]  rd_rank = '0, wr_rank = '0;
   logic [1:0]  rd_bank = '0, wr_bank = '0;
   logic        rd_full, wr_full;
   logic [7:0]  bank_ready = 8'hFF;
   logic        sel_valid, sel_write, issue, switching;
   logic [0:0]  sel_rank;
   logic [1:0]  sel_bank;
   logic [CYC_W-1:0] sel_earliest, cycle_now;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   int n_ev;
   int ev_cyc  [64];
   int ev_rank [64];
   int ev_bank [64];
   bit ev_wr   [64];

   always #4 clk = ~clk;

   burst_sched i_burst_sched (
      .clk(clk), .rst_n(rst_n),
      .rd_push(rd_push), .rd_rank(rd_rank), .rd_bank(rd_bank), .rd_full(rd_full),
      .wr_push(wr_push), .wr_rank(wr_rank), .wr_bank(wr_bank), .wr_full(wr_full),
      .bank_ready(bank_ready),
      .sel_valid(sel_valid), .sel_write(sel_write), .sel_rank(sel_rank),
      .sel_bank(sel_bank), .sel_earliest(sel_earliest),
      .issue(issue), .switching(switching), .cycle_now(cycle_now)
   );

   // Issue log, sampled mid-cycle
   always @(negedge clk) begin
      if (!rst_n) n_ev = 0;
      else if (issue && n_ev < 64) begin
         ev_cyc[n_ev]  = int'(cycle_now);
         ev_rank[n_ev] = int'(sel_rank);
         ev_bank[n_ev] = int'(sel_bank);
         ev_wr[n_ev]   = sel_write;
         n_ev++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int k);
      repeat (k) @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; rd_push = 1'b0; wr_push = 1'b0; bank_ready = 8'hFF;
      step(3);
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic push_rd(input int r, input int b);
      rd_push = 1'b1; rd_rank = 1'(r); rd_bank = 2'(b);
      step(1);
      rd_push = 1'b0;
   endtask

   task automatic push_wr(input int r, input int b);
      wr_push = 1'b1; wr_rank = 1'(r); wr_bank = 2'(b);
      step(1);
      wr_push = 1'b0;
   endtask

   task automatic wait_n(input int k);
      for (int g = 0; g < 300 && n_ev < k; g++) step(1);
   endtask

   task automatic t_reset();
      do_reset();
      chk(sel_valid == 1'b0, "R1 sel_valid", int'(sel_valid), 0);
      chk(issue == 1'b0 && switching == 1'b0, "R1 issue/switching",
          int'({issue, switching}), 0);
      chk(sel_write == 1'b0, "R1 read served", int'(sel_write), 0);
   endtask

   task automatic t_same_rank_reads();
      int c0;
      do_reset();
      push_rd(0, 0);
      c0 = int'(cycle_now);
      push_rd(0, 1);
      push_rd(0, 2);
      wait_n(3);
      chk(ev_cyc[0] == c0, "R12 first burst immediate", ev_cyc[0], c0);
      chk(ev_cyc[1] - ev_cyc[0] == 4, "R2 gap", ev_cyc[1] - ev_cyc[0], 4);
      chk(ev_cyc[2] - ev_cyc[1] == 4, "R2 gap", ev_cyc[2] - ev_cyc[1], 4);
      chk(ev_bank[1] == 1 && ev_bank[2] == 2, "R8 fifo order", ev_bank[1] * 10 + ev_bank[2], 12);
   endtask

   task automatic t_rank_pref_reads();
      do_reset();
      push_rd(0, 0);
      push_rd(1, 0);
      push_rd(0, 1);
      wait_n(3);
      chk(ev_rank[1] == 0 && ev_bank[1] == 1, "R7 same rank first",
          ev_rank[1] * 10 + ev_bank[1], 1);
      chk(ev_cyc[1] - ev_cyc[0] == 4, "R7 no bubble", ev_cyc[1] - ev_cyc[0], 4);
      chk(ev_rank[2] == 1, "R7 other rank last", ev_rank[2], 1);
      chk(ev_cyc[2] - ev_cyc[1] == 6, "R3 read-read rank switch", ev_cyc[2] - ev_cyc[1], 6);
   endtask

   task automatic t_write_rank_switch();
      do_reset();
      push_wr(1, 2);
      push_wr(0, 3);
      wait_n(2);
      chk(n_ev == 2 && ev_wr[0] && ev_wr[1], "R10 switch on empty reads", n_ev, 2);
      chk(ev_rank[0] == 1 && ev_rank[1] == 0, "R8 write order", ev_rank[0] * 10 + ev_rank[1], 10);
      chk(ev_cyc[1] - ev_cyc[0] == 6, "R3 write-write rank switch", ev_cyc[1] - ev_cyc[0], 6);
   endtask

   task automatic t_read_to_write();
      do_reset();
      push_rd(0, 0);
      push_wr(0, 1);
      wait_n(2);
      chk(!ev_wr[0] && ev_wr[1], "R4 direction order", int'(ev_wr[1]), 1);
      chk(ev_cyc[1] - ev_cyc[0] == 10, "R4 read-to-write gap", ev_cyc[1] - ev_cyc[0], 10);
   endtask

   task automatic t_write_to_read_overlap();
      do_reset();
      bank_ready = 8'hFF & ~8'h40;     // rank 1 bank 2 not ready
      push_wr(0, 0);
      wait_n(1);
      push_rd(1, 2);
      step(2);
      chk(switching == 1'b1, "R5 switching to read", int'(switching), 1);
      chk(sel_valid && !sel_write && sel_rank == 1'b1 && sel_bank == 2'd2,
          "R5 read shown before bank ready", int'(sel_valid), 1);
      chk(issue == 1'b0, "R5 no issue while bank not ready", int'(issue), 0);
      bank_ready = 8'hFF;
      wait_n(2);
      chk(ev_cyc[1] - ev_cyc[0] == 14, "R5 R3 write-to-read gap", ev_cyc[1] - ev_cyc[0], 14);
   endtask

   task automatic t_read_to_write_serial();
      int d;
      do_reset();
      bank_ready = 8'hFF & ~8'h20;     // rank 1 bank 1 not ready
      push_rd(0, 0);
      push_wr(1, 1);
      step(4);
      chk(switching == 1'b1 && sel_valid == 1'b0, "R6 write needs ready bank",
          int'(sel_valid), 0);
      step(16);
      chk(n_ev == 1, "R6 write held", n_ev, 1);
      bank_ready = 8'hFF;
      d = int'(cycle_now);
      wait_n(2);
      chk(ev_cyc[1] == d && ev_rank[1] == 1 && ev_wr[1], "R6 write on ready", ev_cyc[1], d);
   endtask

   task automatic t_switch_no_pref();
      do_reset();
      push_rd(1, 0);
      push_wr(0, 0);
      push_wr(1, 1);
      wait_n(3);
      chk(ev_rank[1] == 0, "R9 oldest write during switch", ev_rank[1], 0);
      chk(ev_cyc[1] - ev_cyc[0] == 12, "R3 read-to-write rank gap", ev_cyc[1] - ev_cyc[0], 12);
      chk(ev_rank[2] == 1 && ev_cyc[2] - ev_cyc[1] == 6, "R9 then other rank",
          ev_cyc[2] - ev_cyc[1], 6);
   endtask

   task automatic t_high_water();
      int nw;
      do_reset();
      bank_ready = 8'hF0;              // rank 0 banks not ready
      push_rd(0, 0);
      push_rd(0, 1);
      for (int i = 0; i < 5; i++) push_wr(1, i % 4);
      step(6);
      chk(n_ev == 0 && switching == 1'b0, "R10 below high water", n_ev, 0);
      push_wr(1, 1);
      wait_n(6);
      nw = 0;
      for (int i = 0; i < 6; i++) if (ev_wr[i]) nw++;
      chk(nw == 6, "R10 R11 writes drained first", nw, 6);
      step(2);
      chk(n_ev == 6, "R11 reads wait", n_ev, 6);
      bank_ready = 8'hFF;
      wait_n(8);
      chk(!ev_wr[6] && !ev_wr[7] && ev_bank[6] == 0 && ev_bank[7] == 1,
          "R11 reads after writes", ev_bank[6] * 10 + ev_bank[7], 1);
      chk(ev_cyc[6] - ev_cyc[5] == 14, "R3 write-to-read rank gap", ev_cyc[6] - ev_cyc[5], 14);
   endtask

   initial begin
      t_reset();
      t_same_rank_reads();
      t_rank_pref_reads();
      t_write_rank_switch();
      t_read_to_write();
      t_write_to_read_overlap();
      t_read_to_write_serial();
      t_switch_no_pref();
      t_high_water();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog R1 actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule